// File: doc/BRIEF.md
# Infrared Carrier Burst Generator

This block drives a single push-pull output with a remote-control carrier. A phase timer counts down alternately from a high-phase reload value and a low-phase reload value, so the two halves of the carrier period are set on their own and the duty cycle can be shaped freely. A second down-counter, the burst timer, has one reload value. Each time it underflows it samples a carrier-enable flag, which switches the carrier on and off in hardware and times marks and spaces without CPU involvement at every edge.

A CPU writes the reload values and a small control register over a simple write bus. It sets or clears the carrier-enable flag with two one-cycle strobes. In direct mode the flag itself requests the carrier. In automatic mode the request is the flag value captured at the most recent burst-timer underflow. The burst timer counts either every clock or once per finished carrier period. Whatever the source of the request, it reaches the pin only at the end of a carrier low phase, so every pulse on the pin is complete.

Top module: `carrier_gen`

## Requirements
- R1: After reset both timers are stopped, all reload values and counters are zero, the phase level is high, the enable flag is 0, and `carr_out` is 0.
- R2: A write with `wr_en` high updates the register chosen by `wr_addr` on that clock edge: 0 is the high-phase reload, 1 is the low-phase reload, 2 is the burst reload, and 3 is control. The control bits are bit 0 automatic gating, bit 1 burst timer run, bit 2 burst timer counts carrier periods (0 means every clock), and bit 3 phase timer run.
- R3: `car_set` sets the enable flag and `car_clr` clears it. When both strobes arrive in the same cycle, the clear wins.
- R4: A running phase timer holds its level high for H+1 clocks and then low for L+1 clocks, repeating, where H and L are the high and low reload values. A reload of 0 gives a one-clock phase.
- R5: A stopped timer holds its counter and level. Writing the high-phase reload while the phase timer is stopped also loads its counter. Writing the burst reload while the burst timer is stopped also loads the burst counter.
- R6: A running burst timer decrements on each tick. A tick is every clock, or the end of each carrier low phase when control bit 2 is set. A tick that finds the counter at 0 is an underflow, and it reloads the counter from the burst reload.
- R7: In direct mode the carrier request is the enable flag. In automatic mode the request is the flag value captured at the last burst underflow.
- R8: The applied enable takes the request only in the cycle where a running carrier ends a low phase. `carr_out` is the applied enable AND the phase level, so it never rises or falls in the middle of a phase.
- R9: When a burst underflow and a low-phase end fall in the same cycle, the applied enable takes the capture made before that cycle. The new capture applies at the following low-phase end.
- R10: A reload register written in the same cycle its counter reloads gives the value it held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| car_set | input | 1 | Sets the carrier-enable flag |
| car_clr | input | 1 | Clears the carrier-enable flag (has priority) |
| carr_out | output | 1 | Carrier output pin |

## Verification
The key collision is a burst-timer underflow landing in the same cycle as the end of a carrier low phase. The bench provokes it by making the burst timer count carrier periods with a reload of 0, so every period end is also an underflow. It then checks that the pin follows the older capture for one more period. The other collision is a set strobe and a clear strobe in the same cycle, along with register writes that land on reload cycles. These come from a pseudo-random phase that drives strobes and writes freely. A behavioural model, stepped every clock, judges each cycle of the pin.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_HI_RLD    = 2'd0,
        SEL_LO_RLD    = 2'd1,
        SEL_BURST_RLD = 2'd2,
        SEL_CTRL      = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ph_run;
        logic burst_on_period;
        logic burst_run;
        logic auto_gate;
    } ctrl_t;
endpackage

// File: rtl/carrier_phase_tmr.sv
module carrier_phase_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] hi_reload,
    input  logic [W-1:0] lo_reload,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         level,
    output logic [W-1:0] cnt,
    output logic         period_end
);
    typedef struct packed {
        logic         level;
        logic [W-1:0] cnt;
    } ph_state_t;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    ph_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        period_end = run && (st_q.cnt == '0) && !st_q.level;
        if (run) begin
            if (st_q.cnt == '0) begin
                st_d.level = !st_q.level;
                st_d.cnt   = st_q.level ? lo_reload : hi_reload;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end else if (load) begin
            st_d.cnt = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.level <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.level;
    assign cnt   = st_q.cnt;
endmodule

// File: rtl/carrier_burst_tmr.sv
module carrier_burst_tmr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] reload,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         underflow,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d     = cnt_q;
        underflow = run && tick && (cnt_q == '0);
        if (run && tick) begin
            cnt_d = (cnt_q == '0) ? reload : cnt_q - ONE;
        end else if (!run && load) begin
            cnt_d = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/carrier_gate.sv
module carrier_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic car_set,
    input  logic car_clr,
    input  logic auto_gate,
    input  logic burst_uf,
    input  logic period_end,
    input  logic level,
    output logic flag,
    output logic applied,
    output logic carr
);
    typedef struct packed {
        logic flag;
        logic capt;
        logic applied;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        request;

    always_comb begin
        st_d    = st_q;
        request = auto_gate ? st_q.capt : st_q.flag;
        if (car_clr)      st_d.flag = 1'b0;
        else if (car_set) st_d.flag = 1'b1;
        if (burst_uf)     st_d.capt = st_q.flag;
        if (period_end)   st_d.applied = request;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag    = st_q.flag;
    assign applied = st_q.applied;
    assign carr    = st_q.applied & level;
endmodule

// File: rtl/carrier_gen.sv
module carrier_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         car_set,
    input  logic         car_clr,
    output logic         carr_out
);
    import carrier_pkg::*;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic [W-1:0] hi_rld;
        logic [W-1:0] lo_rld;
        logic [W-1:0] burst_rld;
        ctrl_t        ctrl;
    } regs_t;

    regs_t        rg_d, rg_q;
    logic         ld_hi, ld_burst;
    logic         ph_level, period_end;
    logic [W-1:0] ph_cnt;
    logic         burst_tick, burst_uf;
    logic [W-1:0] burst_cnt;
    logic         flag, applied;

    always_comb begin
        rg_d     = rg_q;
        ld_hi    = 1'b0;
        ld_burst = 1'b0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                SEL_HI_RLD: begin
                    rg_d.hi_rld = wr_data;
                    ld_hi       = !rg_q.ctrl.ph_run;
                end
                SEL_LO_RLD:    rg_d.lo_rld = wr_data;
                SEL_BURST_RLD: begin
                    rg_d.burst_rld = wr_data;
                    ld_burst       = !rg_q.ctrl.burst_run;
                end
                SEL_CTRL:      rg_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
                default:       rg_d = rg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    carrier_phase_tmr #(.W(W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (rg_q.ctrl.ph_run),
        .hi_reload  (rg_q.hi_rld),
        .lo_reload  (rg_q.lo_rld),
        .load       (ld_hi),
        .load_val   (wr_data),
        .level      (ph_level),
        .cnt        (ph_cnt),
        .period_end (period_end)
    );

    assign burst_tick = rg_q.ctrl.burst_on_period ? period_end : 1'b1;

    carrier_burst_tmr #(.W(W)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (rg_q.ctrl.burst_run),
        .tick      (burst_tick),
        .reload    (rg_q.burst_rld),
        .load      (ld_burst),
        .load_val  (wr_data),
        .underflow (burst_uf),
        .cnt       (burst_cnt)
    );

    carrier_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .car_set    (car_set),
        .car_clr    (car_clr),
        .auto_gate  (rg_q.ctrl.auto_gate),
        .burst_uf   (burst_uf),
        .period_end (period_end),
        .level      (ph_level),
        .flag       (flag),
        .applied    (applied),
        .carr       (carr_out)
    );
endmodule

// File: rtl/carrier_gen_chk.sv
module carrier_gen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         car_set,
    input logic         car_clr,
    input logic         carr_out,
    input logic         ph_run,
    input logic         ph_level,
    input logic [W-1:0] ph_cnt,
    input logic         burst_uf,
    input logic [W-1:0] burst_cnt,
    input logic [W-1:0] burst_rld,
    input logic         flag
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        car_clr |=> !flag);

    a_r3_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (car_set && !car_clr) |=> flag);

    a_r4_phase_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_run && ph_cnt != '0) |=> (ph_cnt == $past(ph_cnt) - ONE));

    a_r5_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_run |=> $stable(ph_level));

    a_r6_burst_reload: assert property (@(posedge clk) disable iff (!rst_n)
        burst_uf |=> (burst_cnt == $past(burst_rld)));

    a_r8_rise_on_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carr_out) |-> $rose(ph_level));

    a_r8_fall_on_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carr_out) |-> $fell(ph_level));
endmodule

bind carrier_gen carrier_gen_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .car_set   (car_set),
    .car_clr   (car_clr),
    .carr_out  (carr_out),
    .ph_run    (rg_q.ctrl.ph_run),
    .ph_level  (ph_level),
    .ph_cnt    (ph_cnt),
    .burst_uf  (burst_uf),
    .burst_cnt (burst_cnt),
    .burst_rld (rg_q.burst_rld),
    .flag      (flag)
);

// File: tb/tb_carrier_gen.sv
module tb_carrier_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       car_set = 1'b0;
    logic       car_clr = 1'b0;
    logic       carr_out;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_hi, m_lo, m_bu, m_ctl;
    int m_lvl, m_c2, m_c1, m_flag, m_cap, m_en;

    always #5 clk = ~clk;

    carrier_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .car_set(car_set), .car_clr(car_clr),
        .carr_out(carr_out)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_bu = 0; m_ctl = 0;
            m_lvl = 1; m_c2 = 0; m_c1 = 0; m_flag = 0; m_cap = 0; m_en = 0;
        end else begin
            int n_hi, n_lo, n_bu, n_ctl, n_lvl, n_c2, n_c1, n_flag, n_cap, n_en;
            bit run2, run1, bnd, tick, uf;
            run2 = m_ctl[3]; run1 = m_ctl[1];
            n_hi = m_hi; n_lo = m_lo; n_bu = m_bu; n_ctl = m_ctl;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: n_hi = wr_data;
                    2'd1: n_lo = wr_data;
                    2'd2: n_bu = wr_data;
                    default: n_ctl = wr_data & 15;
                endcase
            end
            n_lvl = m_lvl; n_c2 = m_c2;
            bnd = run2 && m_c2 == 0 && m_lvl == 0;
            if (run2) begin
                if (m_c2 == 0) begin
                    n_lvl = 1 - m_lvl;
                    n_c2 = m_lvl ? m_lo : m_hi;
                end else n_c2 = m_c2 - 1;
            end else if (wr_en && wr_addr == 2'd0) n_c2 = wr_data;
            tick = run1 && (m_ctl[2] ? bnd : 1'b1);
            uf = tick && m_c1 == 0;
            n_c1 = m_c1;
            if (tick) n_c1 = (m_c1 == 0) ? m_bu : m_c1 - 1;
            else if (!run1 && wr_en && wr_addr == 2'd2) n_c1 = wr_data;
            n_flag = car_clr ? 0 : (car_set ? 1 : m_flag);
            n_cap = uf ? m_flag : m_cap;
            n_en = bnd ? (m_ctl[0] ? m_cap : m_flag) : m_en;
            m_hi = n_hi; m_lo = n_lo; m_bu = n_bu; m_ctl = n_ctl;
            m_lvl = n_lvl; m_c2 = n_c2; m_c1 = n_c1;
            m_flag = n_flag; m_cap = n_cap; m_en = n_en;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (carr_out !== 1'((m_en & m_lvl) != 0)) begin
                fails++;
                $display("FAIL %s: carr_out=%0b expected %0b at %0t",
                         cur_req, carr_out, (m_en & m_lvl), $time);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input bit s, input bit c);
        @(negedge clk);
        car_set = s; car_clr = c;
        @(negedge clk);
        car_set = 1'b0; car_clr = 1'b0;
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (carr_out) highs++;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        while (carr_out !== 1'b0) @(negedge clk);
        while (carr_out !== 1'b1) @(negedge clk);
        while (carr_out === 1'b1) begin hi++; @(negedge clk); end
        while (carr_out === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int hi, lo, h;
        bit [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("R1 reset output", carr_out, 0);
        wr(2'd3, 8'h08);           // run carrier with flag still clear
        count_high(30, h);
        check("R1 flag clear keeps pin low", h, 0);
        wr(2'd3, 8'h00);

        cur_req = "R2";
        wr(2'd0, 8'd2);            // stopped: loads phase counter (R5)
        wr(2'd1, 8'd4);
        strobe(1, 0);
        wr(2'd3, 8'h08);           // direct mode, phase timer on
        cur_req = "R4";
        measure(hi, lo);
        check("R4 high width 2+1", hi, 3);
        check("R4 low width 4+1", lo, 5);
        cur_req = "R10";
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        repeat (20) @(negedge clk);
        measure(hi, lo);
        check("R4 zero reload high", hi, 1);
        check("R4 zero reload low", lo, 1);

        cur_req = "R3";
        wr(2'd0, 8'd1); wr(2'd1, 8'd1);
        strobe(1, 1);
        repeat (10) @(negedge clk);
        count_high(20, h);
        check("R3 clear wins over set", h, 0);
        strobe(1, 0);
        repeat (10) @(negedge clk);
        count_high(20, h);
        check("R3 set restores carrier", h, 10);

        cur_req = "R5";
        wr(2'd3, 8'h00);
        @(negedge clk);
        hi = carr_out;
        count_high(15, h);
        check("R5 stopped timer holds pin", h, hi * 15);
        wr(2'd2, 8'd3);            // burst counter loaded while stopped

        cur_req = "R7";
        strobe(0, 1);
        wr(2'd3, 8'h0B);           // auto, burst every clock, carrier on
        strobe(1, 0);
        repeat (40) @(negedge clk);
        count_high(40, h);
        check("R7 auto mode carrier follows capture", (h > 0) ? 1 : 0, 1);
        cur_req = "R6";
        wr(2'd2, 8'd20);
        strobe(0, 1);
        repeat (80) @(negedge clk);
        count_high(20, h);
        check("R6 underflow captures cleared flag", h, 0);

        cur_req = "R9";
        wr(2'd2, 8'd0);
        wr(2'd3, 8'h0F);           // burst counts periods, reload 0
        strobe(1, 0);
        repeat (60) @(negedge clk);
        strobe(0, 1);
        repeat (40) @(negedge clk);
        count_high(20, h);
        check("R9 off after capture chain", h, 0);

        cur_req = "R8";
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            car_set = (lfsr[3:0] == 4'd1) || (lfsr[3:0] == 4'd2);
            car_clr = (lfsr[3:0] == 4'd2) || (lfsr[3:0] == 4'd3);
            wr_en = (lfsr[7:4] == 4'd5);
            wr_addr = lfsr[9:8];
            wr_data = (lfsr[9:8] == 2'd3) ? {4'd0, lfsr[13:10]} : {5'd0, lfsr[12:10]};
        end
        @(negedge clk);
        wr_en = 1'b0; car_set = 1'b0; car_clr = 1'b0;
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule